// File: doc/BRIEF.md
# Read-to-Clear Interrupt Channel Vector Register

This block sits between a 16-channel transfer engine and the processor's register bus. It holds two sets of per-channel pending flags. One set records half-block-complete events and the other records block-complete events. Each set is gated by a per-channel enable for one interrupt group. A single group interrupt line is raised while any enabled flag of either kind is pending.

Software services the interrupt by reading one of two read-only vector registers, one for each event kind. Each read returns a one-based channel code: the lowest-numbered channel that is both pending and enabled. The same read clears the flag of exactly that channel. Repeated reads therefore walk the pending channels in priority order until the register returns zero.

Top module: `irq_chan_vector`

## Requirements
- R1: A vector read returns the winning channel n as code n+1 in bus_rdata[5:0], so channel 0 reads 0x01 and channel 15 reads 0x10. A code of 0 means no enabled channel is pending.
- R2: The code field never holds a value above 0x10. Values 0x11 to 0x3F never appear.
- R3: bus_rdata[31:6] is always zero. A bus write to either vector address leaves the pending flags and the following read value unchanged.
- R4: A channel whose enable for that event kind is low is never reported, even while its flag is pending.
- R5: Among several enabled pending channels, the lowest-numbered one is reported.
- R6: A read that returns a non-zero code clears the pending flag of the reported channel and no other flag.
- R7: If a channel's event strobe is high in the same cycle that a read clears that channel, the flag stays pending.
- R8: A read that returns 0 changes no flag. Flags that are pending but disabled survive such a read and are reported once they are enabled.
- R9: grp_irq is high whenever any enabled pending flag of either kind is set. It goes low in the cycle after the clearing read of the last such flag.
- R10: The half-block-complete vector is at address 0x168 and the block-complete vector is at 0x16C. Each address reports and clears only its own kind of flag. A read of any other address returns 0 and changes no flag.
- R11: After reset all flags are clear, grp_irq is low and bus_rdata is 0. Read data appears on bus_rdata in the cycle after the read cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Registered read data |
| half_evt | input | NCH | Per-channel half-block-complete strobes |
| blk_evt | input | NCH | Per-channel block-complete strobes |
| half_en | input | NCH | Per-channel enables for half-block-complete flags |
| blk_en | input | NCH | Per-channel enables for block-complete flags |
| grp_irq | output | 1 | Group interrupt request |

## Verification
The read code and its clear both take effect at the clock edge that ends the read cycle. The bench therefore compares bus_rdata at the falling edge one cycle after the strobe. The clearing effect is confirmed by the value the next read returns. grp_irq is a combinational function of the flags and enables, so it is sampled at the falling edge right after the clearing edge, or right after an enable change. The driver queues each expected read value when it issues the strobe. The monitor pops that value only in the cycle when the registered data is due, which keeps every comparison tied to that one-cycle latency.

// File: rtl/irq_chan_vector.sv
module irq_chan_vector #(
  parameter int NCH = 16,
  parameter int AW = 12,
  parameter logic [AW-1:0] HBC_OFS = 12'h168,
  parameter logic [AW-1:0] BC_OFS = 12'h16C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] half_evt,
  input  logic [NCH-1:0] blk_evt,
  input  logic [NCH-1:0] half_en,
  input  logic [NCH-1:0] blk_en,
  output logic           grp_irq
);
  localparam int CW = 6;
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic [NCH-1:0] hb_pend, bc_pend, hb_clr, bc_clr;
  logic [CW-1:0]  hb_code, bc_code, rd_code;

  function automatic logic [CW-1:0] encode(input logic [NCH-1:0] v);
    encode = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) encode = CW'(i + 1);
  endfunction

  wire unused_wdata = ^bus_wdata;
  wire rd    = bus_sel & ~bus_wr;
  wire rd_hb = rd && (bus_addr == HBC_OFS);
  wire rd_bc = rd && (bus_addr == BC_OFS);

  assign hb_code = encode(hb_pend & half_en);
  assign bc_code = encode(bc_pend & blk_en);
  assign hb_clr  = (rd_hb && hb_code != '0) ? (ONE << (hb_code - 1'b1)) : '0;
  assign bc_clr  = (rd_bc && bc_code != '0) ? (ONE << (bc_code - 1'b1)) : '0;
  assign rd_code = rd_hb ? hb_code : (rd_bc ? bc_code : '0);
  assign grp_irq = |(hb_pend & half_en) | |(bc_pend & blk_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_pend   <= '0;
      bc_pend   <= '0;
      bus_rdata <= '0;
    end else begin
      hb_pend <= (hb_pend & ~hb_clr) | half_evt;
      bc_pend <= (bc_pend & ~bc_clr) | blk_evt;
      if (rd) bus_rdata <= {{(32-CW){1'b0}}, rd_code};
    end
  end

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[CW-1:0] <= CW'(NCH));
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:CW] == '0);
  assert_one_clear_hb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hb |=> $countones($past(hb_pend) & ~hb_pend) <= 1);
  assert_one_clear_bc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bc |=> $countones($past(bc_pend) & ~bc_pend) <= 1);
  assert_no_drop_hb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hb && hb_code != '0) |=> (($past(hb_pend) & ~hb_pend) == '0));
  assert_no_drop_bc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_bc && bc_code != '0) |=> (($past(bc_pend) & ~bc_pend) == '0));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hb_pend & $past(half_evt)) == $past(half_evt)) &&
             ((bc_pend & $past(blk_evt)) == $past(blk_evt)));
  assert_irq_on_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code != '0) |-> grp_irq);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_chan_vector_bench.sv
module irq_chan_vector_bench;
  localparam int NCH = 16;
  localparam logic [11:0] A_HB = 12'h168, A_BC = 12'h16C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] half_evt = '0, blk_evt = '0, half_en = '0, blk_en = '0;
  logic grp_irq;

  int vectors = 0, errors = 0;
  bit done = 0, due = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  irq_chan_vector u_irq_chan_vector (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .half_evt(half_evt), .blk_evt(blk_evt), .half_en(half_en),
    .blk_en(blk_en), .grp_irq(grp_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) due <= rst_n && bus_sel && !bus_wr;

  always @(negedge clk) if (due) begin
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R11: unexpected read data %h expected none", bus_rdata);
    end else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                    input logic [NCH-1:0] hev = '0, input logic [NCH-1:0] bev = '0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a; half_evt = hev; blk_evt = bev;
    @(negedge clk);
    bus_sel = 0; half_evt = '0; blk_evt = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ev(input logic [NCH-1:0] h, input logic [NCH-1:0] b);
    half_evt = h; blk_evt = b;
    @(negedge clk);
    half_evt = '0; blk_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset rdata", bus_rdata, 0);
    check("R11 reset irq", {31'b0, grp_irq}, 0);

    half_en = '1;
    ev(16'h0024, '0);
    check("R9 irq raised", {31'b0, grp_irq}, 1);
    rd(A_HB, 32'h03, "R5 lowest of ch2,ch5");
    rd(A_HB, 32'h06, "R6 ch5 after ch2 cleared");
    check("R9 irq drops after last clear", {31'b0, grp_irq}, 0);
    rd(A_HB, 32'h00, "R1 empty reads zero");

    ev(16'h8000, '0);
    rd(A_HB, 32'h10, "R1 R2 ch15 code");
    ev(16'h0001, '0);
    rd(A_HB, 32'h01, "R1 ch0 code");

    half_en = 16'h0080;
    ev(16'h0088, '0);
    rd(A_HB, 32'h08, "R4 disabled ch3 skipped");
    rd(A_HB, 32'h00, "R8 only disabled pending");
    check("R9 irq low with disabled pending", {31'b0, grp_irq}, 0);
    half_en = '1;
    @(negedge clk);
    check("R9 irq on enable", {31'b0, grp_irq}, 1);
    rd(A_HB, 32'h04, "R8 ch3 survived zero read");

    blk_en = '1;
    ev('0, 16'h0001);
    rd(A_HB, 32'h00, "R10 half vector ignores block flags");
    rd(A_BC, 32'h01, "R10 block vector ch0");

    ev('0, 16'h0200);
    wr(A_BC, 32'hFFFF_FFFF);
    rd(A_BC, 32'h0A, "R3 write had no effect");
    rd(A_BC, 32'h00, "R3 cleared after read");

    ev('0, 16'h0010);
    rd(A_BC, 32'h05, "R7 read with coincident strobe", '0, 16'h0010);
    rd(A_BC, 32'h05, "R7 flag kept by set");
    rd(A_BC, 32'h00, "R7 then cleared");

    ev(16'h0002, '0);
    rd(12'h170, 32'h00, "R10 other address reads zero");
    rd(A_HB, 32'h02, "R10 other address left flag");

    blk_en = '0;
    ev('0, 16'h0004);
    check("R9 irq low, block disabled", {31'b0, grp_irq}, 0);
    blk_en = 16'h0004;
    @(negedge clk);
    check("R9 irq from block flag", {31'b0, grp_irq}, 1);
    rd(A_BC, 32'h03, "R1 block ch2");
    check("R9 irq low after clear", {31'b0, grp_irq}, 0);
    repeat (3) @(negedge clk);
    check("R11 rdata holds", bus_rdata, 32'h03);

    repeat (2) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule